// File: doc/BRIEF.md
# PHY Control-Register Write Sequencer

This block writes 16-bit values into the internal control registers of a PHY through a narrow port. The port has one shared 16-bit input bus and three strobe lines, one each for address capture, data capture and commit. A register write is three sub-handshakes in sequence. The block places the address on the shared bus and raises the address strobe. It then places the data and raises the data strobe. Last it raises the commit strobe without changing the bus. Each strobe stays high until the PHY reports on a matching clear line that it has consumed the step. The clear line is sampled once per microsecond tick, and the tick comes from a parameterised prescaler on the system clock.

Each step has its own bound on how long it waits. When a step gets no clear within the poll limit, the block drops the strobe and skips the rest of that write. It then pulses an error and reports the value that step was moving: the address, the data, or zero for the commit step. A successful write ends with a one-cycle done pulse. Requests arrive on a valid/ready handshake.

A start pulse makes the block replay a fixed three-write tuning script of its own. The script uses the same step engine and reports done or error once per write.

Top module: `phy_crw_master`

## Requirements
- R1: After reset, req_ready is 1, all three strobes are 0, wr_done and wr_err are 0 and phy_din is 0x0000.
- R2: An accepted write raises adr_stb, then dat_stb, then cmt_stb, in that order. At most one strobe is high at any time, and each rises only after the previous step has finished.
- R3: phy_din carries the request address before and during adr_stb, and the request data before and during dat_stb. It does not change while any strobe is high.
- R4: During cmt_stb, phy_din keeps the data value of the same write. The commit step drives no new value.
- R5: A strobe stays high until its clear input is seen high on a poll tick. It falls within TICK_DIV clock cycles after the clear input rises.
- R6: If a step sees its clear input low on POLL_LIMIT consecutive poll ticks, its strobe falls. wr_err then pulses for one cycle, with err_value set to the address (address step), the data (data step) or 0x0000 (commit step). No later strobe of that write is raised, and req_ready returns to 1. The strobe stays high for between (POLL_LIMIT-1)*TICK_DIV+1 and POLL_LIMIT*TICK_DIV cycles.
- R7: wr_done pulses for exactly one cycle when the commit step of a write completes. req_ready is 0 while any write is in progress.
- R8: A pulse on script_start in idle replays three writes in this order: address 0x1006 with data 0x0C80 (bits 11 and 7 set, 4 in bits 10:8), then address 0x1002 with data 0x4BEE (bit 14 set, 23 in bits 13:7, 110 in bits 6:0), then address 0x102D with data 0x0080. There is one wr_done per write.
- R9: When script_start and req_valid are both high in the same idle cycle, the script wins. req_ready is 0 in that cycle, and the request's address never appears on phy_din.
- R10: If a script write times out, the script still goes on to its next entry. Each failing entry produces its own wr_err with its own value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, releases synchronously |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_addr | input | 16 | PHY register address of the request |
| req_data | input | 16 | Value to write |
| script_start | input | 1 | Start replay of the built-in tuning script |
| phy_din | output | 16 | Shared data-in bus to the PHY |
| adr_stb | output | 1 | Address capture strobe |
| adr_clr | input | 1 | PHY has consumed the address capture |
| dat_stb | output | 1 | Data capture strobe |
| dat_clr | input | 1 | PHY has consumed the data capture |
| cmt_stb | output | 1 | Commit (write acknowledge) strobe |
| cmt_clr | input | 1 | PHY has consumed the commit |
| wr_done | output | 1 | One-cycle pulse: a write completed |
| wr_err | output | 1 | One-cycle pulse: a step timed out |
| err_value | output | 16 | Value of the step that timed out |

## Verification
Writes are tried with a PHY model that clears at once, and with one that clears after a different delay on each step. A delay that differs per step shows which strobe is waiting on which clear line. Timeouts are forced in turn on the address, data and commit steps. Each forced timeout shows whether the error carries the right step's value and whether the later strobes are suppressed. Address and data patterns are chosen so a swapped or stale bus value is visible, such as all ones against all zeros and a single set bit at either end. The script is run once with fast clears, once with a stuck data step, and once against a competing request, to separate ordering, continuation after errors and start priority.

// File: rtl/phy_crw_pkg.sv
package phy_crw_pkg;

  typedef enum logic [1:0] {PH_ADR = 2'd0, PH_DAT = 2'd1, PH_CMT = 2'd2} phase_t;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_LAUNCH = 2'd1, ST_WAIT = 2'd2} state_t;

  localparam int SCRIPT_LEN = 3;

  function automatic logic [15:0] script_addr(input logic [1:0] idx);
    case (idx)
      2'd0:    script_addr = 16'h1006;
      2'd1:    script_addr = 16'h1002;
      default: script_addr = 16'h102D;
    endcase
  endfunction

  function automatic logic [15:0] script_data(input logic [1:0] idx);
    case (idx)
      2'd0:    script_data = (16'd1 << 11) | (16'd4 << 8) | (16'd1 << 7);
      2'd1:    script_data = (16'd1 << 14) | (16'd23 << 7) | 16'd110;
      default: script_data = 16'h0080;
    endcase
  endfunction

endpackage

// File: rtl/phy_crw_tick.sv
module phy_crw_tick #(
  parameter int TICK_DIV = 125
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == LAST);

  always_comb begin
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/phy_crw_poll.sv
module phy_crw_poll #(
  parameter int POLL_LIMIT = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic tick,
  input  logic ack,
  output logic hit,
  output logic expire
);
  localparam int PW = $clog2(POLL_LIMIT + 1);
  localparam logic [PW-1:0] LAST = PW'(POLL_LIMIT - 1);

  logic [PW-1:0] cnt_q, cnt_d;
  logic          poll;

  assign poll   = en & tick;
  assign hit    = poll & ack;
  assign expire = poll & ~ack & (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)               cnt_d = '0;
    else if (poll && !ack) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/phy_crw_master.sv
module phy_crw_master
  import phy_crw_pkg::*;
#(
  parameter int TICK_DIV   = 125,
  parameter int POLL_LIMIT = 100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [15:0] req_addr,
  input  logic [15:0] req_data,
  input  logic        script_start,
  output logic [15:0] phy_din,
  output logic        adr_stb,
  input  logic        adr_clr,
  output logic        dat_stb,
  input  logic        dat_clr,
  output logic        cmt_stb,
  input  logic        cmt_clr,
  output logic        wr_done,
  output logic        wr_err,
  output logic [15:0] err_value
);
  localparam logic [1:0] SCR_LAST = 2'(SCRIPT_LEN - 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  logic tick, hit, expire, ack_sel;

  state_t      st_q, st_d;
  phase_t      ph_q, ph_d;
  logic [15:0] addr_q, addr_d, data_q, data_d, din_q, din_d, ev_q, ev_d;
  logic        scr_q, scr_d, done_q, done_d, err_q, err_d;
  logic [1:0]  idx_q, idx_d;
  logic [2:0]  stb;

  phy_crw_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_i_n), .tick(tick)
  );

  phy_crw_poll #(.POLL_LIMIT(POLL_LIMIT)) u_poll (
    .clk(clk), .rst_n(rst_i_n),
    .clr(st_q == ST_LAUNCH), .en(st_q == ST_WAIT),
    .tick(tick), .ack(ack_sel), .hit(hit), .expire(expire)
  );

  always_comb begin
    case (ph_q)
      PH_ADR:  ack_sel = adr_clr;
      PH_DAT:  ack_sel = dat_clr;
      default: ack_sel = cmt_clr;
    endcase
  end

  assign stb       = (st_q == ST_WAIT) ? (3'b001 << ph_q) : 3'b000;
  assign adr_stb   = stb[0];
  assign dat_stb   = stb[1];
  assign cmt_stb   = stb[2];
  assign req_ready = (st_q == ST_IDLE) & ~script_start;
  assign phy_din   = din_q;
  assign wr_done   = done_q;
  assign wr_err    = err_q;
  assign err_value = ev_q;

  // next-state logic
  always_comb begin
    st_d   = st_q;
    ph_d   = ph_q;
    addr_d = addr_q;
    data_d = data_q;
    din_d  = din_q;
    ev_d   = ev_q;
    scr_d  = scr_q;
    idx_d  = idx_q;
    done_d = 1'b0;
    err_d  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (script_start) begin
          scr_d  = 1'b1;
          idx_d  = 2'd0;
          addr_d = script_addr(2'd0);
          data_d = script_data(2'd0);
          din_d  = script_addr(2'd0);
          ph_d   = PH_ADR;
          st_d   = ST_LAUNCH;
        end else if (req_valid) begin
          addr_d = req_addr;
          data_d = req_data;
          din_d  = req_addr;
          ph_d   = PH_ADR;
          st_d   = ST_LAUNCH;
        end
      end
      ST_LAUNCH: st_d = ST_WAIT;
      default: begin
        if (hit && ph_q != PH_CMT) begin
          ph_d  = (ph_q == PH_ADR) ? PH_DAT : PH_CMT;
          if (ph_q == PH_ADR) din_d = data_q;
          st_d  = ST_LAUNCH;
        end else if (hit || expire) begin
          done_d = hit;
          err_d  = expire;
          if (expire) begin
            case (ph_q)
              PH_ADR:  ev_d = addr_q;
              PH_DAT:  ev_d = data_q;
              default: ev_d = 16'h0000;
            endcase
          end
          if (scr_q && idx_q != SCR_LAST) begin
            idx_d  = idx_q + 2'd1;
            addr_d = script_addr(idx_q + 2'd1);
            data_d = script_data(idx_q + 2'd1);
            din_d  = script_addr(idx_q + 2'd1);
            ph_d   = PH_ADR;
            st_d   = ST_LAUNCH;
          end else begin
            scr_d = 1'b0;
            st_d  = ST_IDLE;
          end
        end
      end
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q   <= ST_IDLE;
      ph_q   <= PH_ADR;
      addr_q <= '0;
      data_q <= '0;
      din_q  <= '0;
      ev_q   <= '0;
      scr_q  <= 1'b0;
      idx_q  <= 2'd0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      addr_q <= addr_d;
      data_q <= data_d;
      din_q  <= din_d;
      ev_q   <= ev_d;
      scr_q  <= scr_d;
      idx_q  <= idx_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end
endmodule

// File: rtl/phy_crw_master_chk.sv
module phy_crw_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic [15:0] phy_din,
  input logic        adr_stb,
  input logic        adr_clr,
  input logic        dat_stb,
  input logic        dat_clr,
  input logic        cmt_stb,
  input logic        cmt_clr,
  input logic        wr_done,
  input logic        wr_err
);
  logic [2:0] s, c;
  assign s = {cmt_stb, dat_stb, adr_stb};
  assign c = {cmt_clr, dat_clr, adr_clr};

  // R2: never two strobes at once
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(s));

  // R3: bus is held while a strobe stays high
  a_r3_din_held: assert property (@(posedge clk) disable iff (!rst_n)
    (|s) && $past(|s) |-> $stable(phy_din));

  // R7: not ready while a step is in flight
  a_r7_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (|s) |-> !req_ready);

  // R7: done is a single-cycle pulse, never together with an error
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !wr_done);
  a_r7_done_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_done && wr_err));

  // R6: a strobe that falls without its clear is reported as an error
  a_r6_drop_without_clr: assert property (@(posedge clk) disable iff (!rst_n)
    $past(|(s & ~c)) && (s == 3'b000) |-> wr_err);
endmodule

bind phy_crw_master phy_crw_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .phy_din(phy_din),
  .adr_stb(adr_stb), .adr_clr(adr_clr), .dat_stb(dat_stb), .dat_clr(dat_clr),
  .cmt_stb(cmt_stb), .cmt_clr(cmt_clr), .wr_done(wr_done), .wr_err(wr_err)
);

// File: tb/phy_crw_master_bench.sv
module phy_crw_master_bench;
  localparam int DIV = 4;
  localparam int LIM = 100;
  localparam int NV  = 6;
  localparam logic [7:0] NEVER = 8'hFF;

  // fields: addr[79:64] data[63:48] d0[47:40] d1[39:32] d2[31:24] n[23:20] err[16] val[15:0]
  localparam logic [79:0] VEC [NV] = '{
    {16'h1234, 16'hABCD, 8'd0,  8'd0,  8'd0,  4'd3, 4'd0, 16'h0000},
    {16'hFFFF, 16'h0000, 8'd5,  8'd9,  8'd2,  4'd3, 4'd0, 16'h0000},
    {16'h0001, 16'h8000, NEVER, 8'd0,  8'd0,  4'd1, 4'd1, 16'h0001},
    {16'h5A5A, 16'hC3C3, 8'd3,  NEVER, 8'd0,  4'd2, 4'd1, 16'hC3C3},
    {16'h0F0F, 16'h7777, 8'd1,  8'd1,  NEVER, 4'd3, 4'd1, 16'h0000},
    {16'hA5A5, 16'h1111, 8'd20, 8'd0,  8'd7,  4'd3, 4'd0, 16'h0000}
  };

  logic clk, rst_n, req_valid, req_ready, script_start;
  logic [15:0] req_addr, req_data, phy_din, err_value;
  logic adr_stb, adr_clr, dat_stb, dat_clr, cmt_stb, cmt_clr, wr_done, wr_err;

  phy_crw_master #(.TICK_DIV(DIV), .POLL_LIMIT(LIM)) u_phy_crw_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .script_start(script_start),
    .phy_din(phy_din), .adr_stb(adr_stb), .adr_clr(adr_clr),
    .dat_stb(dat_stb), .dat_clr(dat_clr), .cmt_stb(cmt_stb), .cmt_clr(cmt_clr),
    .wr_done(wr_done), .wr_err(wr_err), .err_value(err_value)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int applied = 0, miscompares = 0;
  logic [7:0] dly [3];
  int nrec, done_cnt, err_cnt, lat_max, last_hi, busy_ready, done_wide;
  int rec_ch [16];
  logic [15:0] rec_din [16];
  logic [15:0] ev_rec [4];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    nrec = 0; done_cnt = 0; err_cnt = 0; lat_max = 0; last_hi = 0;
    busy_ready = 0; done_wide = 0;
  endtask

  // PHY model and monitor
  initial begin
    logic [2:0] prev, s;
    logic prev_done;
    int cnt [3], hi [3], lat [3];
    logic [2:0] a;
    prev = 3'b000; prev_done = 1'b0; a = 3'b000;
    for (int i = 0; i < 3; i++) begin cnt[i] = 0; hi[i] = 0; lat[i] = 0; end
    {cmt_clr, dat_clr, adr_clr} = 3'b000;
    forever begin
      @(negedge clk);
      s = {cmt_stb, dat_stb, adr_stb};
      if (|s && req_ready) busy_ready++;
      if (wr_done && prev_done) done_wide++;
      prev_done = wr_done;
      if (wr_done) done_cnt++;
      if (wr_err) begin
        if (err_cnt < 4) ev_rec[err_cnt] = err_value;
        err_cnt++;
      end
      for (int c = 0; c < 3; c++) begin
        if (s[c] && !prev[c] && nrec < 16) begin
          rec_ch[nrec] = c; rec_din[nrec] = phy_din; nrec++;
        end
        if (s[c]) begin
          hi[c]++;
          if (a[c]) lat[c]++;
          cnt[c]++;
          a[c] = (dly[c] != NEVER) && (cnt[c] > int'(dly[c]));
        end else begin
          if (prev[c]) begin
            last_hi = hi[c];
            if (lat[c] > lat_max) lat_max = lat[c];
          end
          hi[c] = 0; lat[c] = 0; cnt[c] = 0; a[c] = 1'b0;
        end
      end
      {cmt_clr, dat_clr, adr_clr} = a;
      prev = s;
    end
  end

  task automatic wait_quiet(input int n_end);
    int w;
    w = 0;
    while ((done_cnt + err_cnt) < n_end && w < 5000) begin
      @(negedge clk); w++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic send(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    req_addr = a; req_data = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    logic [15:0] exp_a [3], exp_d [3];
    exp_a[0] = 16'h1006; exp_d[0] = 16'h0C80;
    exp_a[1] = 16'h1002; exp_d[1] = (16'd1 << 14) | (16'd23 << 7) | 16'd110;
    exp_a[2] = 16'h102D; exp_d[2] = 16'h0080;
    dly[0] = 8'd0; dly[1] = 8'd0; dly[2] = 8'd0;
    req_valid = 1'b0; script_start = 1'b0; req_addr = '0; req_data = '0;
    clear_mon();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 ready", req_ready, 1);
    chk("R1 strobes", {adr_stb, dat_stb, cmt_stb}, 0);
    chk("R1 done/err", {wr_done, wr_err}, 0);
    chk("R1 din", phy_din, 0);

    // table of single writes
    for (int v = 0; v < NV; v++) begin
      logic [79:0] t;
      t = VEC[v];
      dly[0] = t[47:40]; dly[1] = t[39:32]; dly[2] = t[31:24];
      clear_mon();
      send(t[79:64], t[63:48]);
      wait_quiet(1);
      chk("R2 strobe count", nrec, t[23:20]);
      for (int k = 0; k < 3; k++) begin
        if (k < nrec) begin
          chk("R2 order", rec_ch[k], k);
          chk(k == 0 ? "R3 addr on bus" : (k == 1 ? "R3 data on bus" : "R4 bus held at commit"),
              rec_din[k], k == 0 ? t[79:64] : t[63:48]);
        end
      end
      if (t[16]) begin
        chk("R6 err count", err_cnt, 1);
        chk("R6 err value", ev_rec[0], t[15:0]);
        chk("R6 timeout length in range",
            (last_hi >= (LIM-1)*DIV+1) && (last_hi <= LIM*DIV), 1);
        chk("R6 no done", done_cnt, 0);
      end else begin
        chk("R7 done count", done_cnt, 1);
        chk("R7 no err", err_cnt, 0);
        chk("R5 clear-to-fall latency", lat_max < DIV, 1);
      end
      chk("R7 not ready while busy", busy_ready, 0);
      chk("R7 done single cycle", done_wide, 0);
      chk("R6 ready back", req_ready, 1);
    end

    // R8 and R9: script start with a competing request
    dly[0] = 8'd2; dly[1] = 8'd0; dly[2] = 8'd1;
    clear_mon();
    @(negedge clk);
    req_addr = 16'hDEAD; req_data = 16'hBEEF; req_valid = 1'b1; script_start = 1'b1;
    #1;
    chk("R9 ready low on script start", req_ready, 0);
    @(negedge clk);
    req_valid = 1'b0; script_start = 1'b0;
    wait_quiet(3);
    chk("R8 strobe count", nrec, 9);
    chk("R8 done count", done_cnt, 3);
    chk("R8 no err", err_cnt, 0);
    for (int k = 0; k < 9 && k < nrec; k++) begin
      chk("R8 order", rec_ch[k], k % 3);
      chk("R8 script value", rec_din[k], (k % 3 == 0) ? exp_a[k/3] : exp_d[k/3]);
    end
    chk("R9 request dropped", (rec_din[0] == 16'hDEAD), 0);

    // R10: data step never clears, every script entry times out
    dly[0] = 8'd0; dly[1] = NEVER; dly[2] = 8'd0;
    clear_mon();
    @(negedge clk); script_start = 1'b1;
    @(negedge clk); script_start = 1'b0;
    wait_quiet(3);
    chk("R10 err count", err_cnt, 3);
    chk("R10 strobe count", nrec, 6);
    chk("R10 no done", done_cnt, 0);
    for (int k = 0; k < 3; k++) chk("R10 err value", ev_rec[k], exp_d[k]);
    chk("R10 ready back", req_ready, 1);

    summary();
  end
endmodule